// File: doc/BRIEF.md
# Program Sequencer With Skip Handling

This block owns the program counter and the hardware return stack of a processor core that issues one 14-bit instruction per cycle. The instruction register outside the block presents, in each cycle, the word read from the address the block drove as `fetch_addr` in the previous cycle. That register must load a NOP (all zeros) while reset is active. The block decodes the control-flow part of each word and decides the next fetch address. The data path supplies a zero flag and a tested bit value for conditional skips.

Every taken jump, call, return, true skip and interrupt entry marks the slot already in flight as dead by raising `squash` for one cycle. The data path must then treat that slot as a NOP, so each of these instructions costs two cycles. A controller with two named states does the work. In `ST_EXEC` the presented instruction is live. `ST_EXEC -> ST_FLUSH` happens on any redirect or true skip. In `ST_FLUSH` the presented slot is dead, and the state returns unconditionally with `ST_FLUSH -> ST_EXEC`. A literal return also hands its 8-bit constant to the working register through `w_load` / `w_lit`.

Top module: `prog_sequencer`

## Requirements
- R1: While reset is active and in the first cycle after it, `fetch_addr` is 0x000, `squash` is 0 and `gie` is 0. The stack pointer starts at entry 0.
- R2: A live instruction that is not a jump, call, return or skip advances `fetch_addr` by one, and `squash` stays 0 in the next cycle.
- R3: A live jump, encoded as bits 13:11 = 101 with the target in bits 10:0, loads the target into `fetch_addr` and raises `squash` for the next cycle.
- R4: A live call, encoded as bits 13:11 = 100 with the target in bits 10:0, pushes the current `fetch_addr` (the address after the call), jumps to the target and raises `squash` for the next cycle.
- R5: A live plain return (word 0x0008) pops the stack into `fetch_addr` and raises `squash` for the next cycle.
- R6: A live literal return (bits 13:10 = 1101, literal in bits 7:0) behaves like R5. In its own cycle it also drives `w_load` = 1, and `w_lit` equals the literal.
- R7: A live interrupt return (word 0x0009) behaves like R5 and sets `gie` to 1.
- R8: Decrement-skip (bits 13:8 = 001011) and increment-skip (bits 13:8 = 001111) raise `squash` for the next slot only when `cond_zero` is 1. `fetch_addr` advances by one in both cases.
- R9: Bit-test-skip-if-clear (bits 13:10 = 0110) skips when `bit_val` is 0. Bit-test-skip-if-set (bits 13:10 = 0111) skips when `bit_val` is 1. A skip has the same effect as in R8.
- R10: `squash` lasts exactly one cycle. During that cycle the presented word, `cond_zero`, `bit_val` and `irq` have no effect, and `fetch_addr` advances by one.
- R11: With `gie` = 1, `irq` = 1 during a live instruction of the R2 kind pushes the current `fetch_addr`, jumps to 0x004, clears `gie` and raises `squash`. `irq` has no effect when `gie` is 0, during a dead slot, or during a redirecting instruction (the request waits).
- R12: The stack holds 8 entries and wraps circularly. After nine pushes, the ninth value has overwritten the first, and nine pops return the pushed values newest first, then the ninth value again.
- R13: The sleep (0x0063) and watchdog-clear (0x0064) words sequence like R2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| insn | input | 14 | Instruction word presented this cycle |
| cond_zero | input | 1 | Zero result of the current decrement/increment |
| bit_val | input | 1 | Value of the bit under test |
| irq | input | 1 | Interrupt request |
| fetch_addr | output | 11 | Address of the next word to read |
| squash | output | 1 | Presented slot is dead and executes as NOP |
| gie | output | 1 | Global interrupt enable |
| w_load | output | 1 | Load working register from `w_lit` |
| w_lit | output | 8 | Literal of a literal return |

## Verification
The embedded properties check several rules on every cycle. A dead slot lasts one cycle and advances the counter by one. Every pop and every rise of `gie` coincides with entering `ST_FLUSH`. A fall of `gie` always lands on the vector. The stack never pushes and pops together. Whether a skip fires for the right polarity of `cond_zero` or `bit_val`, the exact return address popped after circular overwrite, and the deferral of a pending interrupt past a redirect can only be shown by the bench's scenarios, which compare `fetch_addr` against addresses worked out from the program being fed.

// File: rtl/seq_pkg.sv
package seq_pkg;

    localparam int INSN_W = 14;
    localparam int TGT_W  = 11;
    localparam int LIT_W  = 8;

    typedef enum logic [3:0] {
        OP_SEQ,
        OP_GOTO,
        OP_CALL,
        OP_RET,
        OP_RETLW,
        OP_RETFIE,
        OP_SKZ,
        OP_SKBC,
        OP_SKBS
    } op_cls_e;

    typedef enum logic [0:0] {
        ST_EXEC,
        ST_FLUSH
    } seq_state_e;

endpackage

// File: rtl/seq_decode.sv
module seq_decode
    import seq_pkg::*;
(
    input  logic [INSN_W-1:0] insn,
    output op_cls_e           cls,
    output logic [TGT_W-1:0]  target,
    output logic [LIT_W-1:0]  lit
);

    assign target = insn[TGT_W-1:0];
    assign lit    = insn[LIT_W-1:0];

    always_comb begin
        casez (insn)
            14'b10_0???_????_???? : cls = OP_CALL;
            14'b10_1???_????_???? : cls = OP_GOTO;
            14'b11_01??_????_???? : cls = OP_RETLW;
            14'b00_0000_0000_1000 : cls = OP_RET;
            14'b00_0000_0000_1001 : cls = OP_RETFIE;
            14'b00_1011_????_???? : cls = OP_SKZ;
            14'b00_1111_????_???? : cls = OP_SKZ;
            14'b01_10??_????_???? : cls = OP_SKBC;
            14'b01_11??_????_???? : cls = OP_SKBS;
            default               : cls = OP_SEQ;
        endcase
    end

endmodule

// File: rtl/seq_stack.sv
module seq_stack #(
    parameter int DEPTH = 8,
    parameter int W     = 11
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic         pop,
    input  logic [W-1:0] din,
    output logic [W-1:0] top
);

    localparam int PTR_W = (DEPTH > 2) ? $clog2(DEPTH) : 1;

    logic [PTR_W-1:0] sp;
    logic [W-1:0]     mem [DEPTH];

    function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    function automatic logic [PTR_W-1:0] ptr_dec(input logic [PTR_W-1:0] p);
        return (p == '0) ? PTR_W'(DEPTH - 1) : p - 1'b1;
    endfunction

    assign top = mem[ptr_dec(sp)];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sp <= '0;
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else if (push) begin
            mem[sp] <= din;
            sp      <= ptr_inc(sp);
        end else if (pop) begin
            sp <= ptr_dec(sp);
        end
    end

    // R12: one stack operation per cycle
    p_push_pop_excl_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !(push && pop));

    // R12: pointer moves one place forward, wrapping at the depth
    p_push_step_r12: assert property (@(posedge clk) disable iff (!rst_n)
        push |=> sp == ptr_inc($past(sp)));

    // R12: pushed value is on top afterwards
    p_push_top_r12: assert property (@(posedge clk) disable iff (!rst_n)
        push |=> top == $past(din));

endmodule

// File: rtl/seq_ctrl.sv
module seq_ctrl
    import seq_pkg::*;
#(
    parameter int ADDR_W     = 11,
    parameter int IRQ_VECTOR = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  op_cls_e           cls,
    input  logic [TGT_W-1:0]  target,
    input  logic              cond_zero,
    input  logic              bit_val,
    input  logic              irq,
    input  logic [ADDR_W-1:0] top,
    output logic [ADDR_W-1:0] pc,
    output logic              squash,
    output logic              gie,
    output logic              push,
    output logic              pop,
    output logic [ADDR_W-1:0] push_data,
    output logic              w_load
);

    localparam logic [ADDR_W-1:0] VEC_A = IRQ_VECTOR[ADDR_W-1:0];
    localparam logic [ADDR_W-1:0] ONE_A = ADDR_W'(1);

    seq_state_e        state_q, state_d;
    logic [ADDR_W-1:0] pc_q, pc_d, tgt_a;
    logic              gie_q, gie_d;
    logic              live, skip_true, is_ret, irq_take;

    assign live  = (state_q == ST_EXEC);
    assign tgt_a = ADDR_W'(target);

    always_comb begin
        case (cls)
            OP_SKZ:  skip_true = cond_zero;
            OP_SKBC: skip_true = !bit_val;
            OP_SKBS: skip_true = bit_val;
            default: skip_true = 1'b0;
        endcase
    end

    assign is_ret   = (cls == OP_RET) || (cls == OP_RETLW) || (cls == OP_RETFIE);
    assign irq_take = live && gie_q && irq && (cls == OP_SEQ);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_EXEC;
            pc_q    <= '0;
            gie_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            pc_q    <= pc_d;
            gie_q   <= gie_d;
        end
    end

    // transitions
    always_comb begin
        state_d = ST_EXEC;
        pc_d    = pc_q + ONE_A;
        gie_d   = gie_q;
        unique case (state_q)
            ST_FLUSH: begin
                state_d = ST_EXEC;
            end
            ST_EXEC: begin
                case (cls)
                    OP_GOTO, OP_CALL: begin
                        pc_d    = tgt_a;
                        state_d = ST_FLUSH;
                    end
                    OP_RET, OP_RETLW: begin
                        pc_d    = top;
                        state_d = ST_FLUSH;
                    end
                    OP_RETFIE: begin
                        pc_d    = top;
                        gie_d   = 1'b1;
                        state_d = ST_FLUSH;
                    end
                    OP_SKZ, OP_SKBC, OP_SKBS: begin
                        if (skip_true) state_d = ST_FLUSH;
                    end
                    default: begin
                        if (irq_take) begin
                            pc_d    = VEC_A;
                            gie_d   = 1'b0;
                            state_d = ST_FLUSH;
                        end
                    end
                endcase
            end
            default: state_d = ST_EXEC;
        endcase
    end

    // outputs
    always_comb begin
        push      = live && ((cls == OP_CALL) || irq_take);
        pop       = live && is_ret;
        w_load    = live && (cls == OP_RETLW);
        push_data = pc_q;
        pc        = pc_q;
        squash    = (state_q == ST_FLUSH);
        gie       = gie_q;
    end

    // R10: a dead slot lasts one cycle
    p_flush_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_FLUSH) |=> (state_q == ST_EXEC));

    // R10: during a dead slot the counter only steps
    p_flush_step_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_FLUSH) |=> pc_q == $past(pc_q) + ONE_A);

    // R2: plain live instruction without interrupt steps with no dead slot
    p_seq_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (live && cls == OP_SEQ && !(gie_q && irq))
        |=> (pc_q == $past(pc_q) + ONE_A) && (state_q == ST_EXEC));

    // R4: call lands on its target
    p_call_target_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (live && cls == OP_CALL) |=> (pc_q == $past(tgt_a)) && (state_q == ST_FLUSH));

    // R5: any pop is followed by a dead slot
    p_ret_flush_r5: assert property (@(posedge clk) disable iff (!rst_n)
        pop |=> (state_q == ST_FLUSH));

    // R6: literal hand-off only with a return
    p_wload_pop_r6: assert property (@(posedge clk) disable iff (!rst_n)
        w_load |-> pop);

    // R7: enable rises only when entering a dead slot
    p_gie_rise_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(gie_q) |-> (state_q == ST_FLUSH));

    // R11: enable falls only on interrupt entry at the vector
    p_irq_vector_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(gie_q) |-> (pc_q == VEC_A) && (state_q == ST_FLUSH));

endmodule

// File: rtl/prog_sequencer.sv
module prog_sequencer
    import seq_pkg::*;
#(
    parameter int ADDR_W      = 11,
    parameter int STACK_DEPTH = 8,
    parameter int IRQ_VECTOR  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [13:0]       insn,
    input  logic              cond_zero,
    input  logic              bit_val,
    input  logic              irq,
    output logic [ADDR_W-1:0] fetch_addr,
    output logic              squash,
    output logic              gie,
    output logic              w_load,
    output logic [7:0]        w_lit
);

    op_cls_e           cls;
    logic [TGT_W-1:0]  target;
    logic [LIT_W-1:0]  lit;
    logic              push, pop;
    logic [ADDR_W-1:0] push_data, top;

    seq_decode u_dec (
        .insn   (insn),
        .cls    (cls),
        .target (target),
        .lit    (lit)
    );

    seq_stack #(
        .DEPTH (STACK_DEPTH),
        .W     (ADDR_W)
    ) u_stk (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (push),
        .pop   (pop),
        .din   (push_data),
        .top   (top)
    );

    seq_ctrl #(
        .ADDR_W     (ADDR_W),
        .IRQ_VECTOR (IRQ_VECTOR)
    ) u_ctl (
        .clk       (clk),
        .rst_n     (rst_n),
        .cls       (cls),
        .target    (target),
        .cond_zero (cond_zero),
        .bit_val   (bit_val),
        .irq       (irq),
        .top       (top),
        .pc        (fetch_addr),
        .squash    (squash),
        .gie       (gie),
        .push      (push),
        .pop       (pop),
        .push_data (push_data),
        .w_load    (w_load)
    );

    assign w_lit = lit;

    // R10: a dead slot never hands a literal to the working register
    p_squash_no_wload_r10: assert property (@(posedge clk) disable iff (!rst_n)
        squash |-> !w_load);

endmodule

// File: tb/prog_sequencer_test.sv
module prog_sequencer_test;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [13:0] insn;
    logic        cond_zero, bit_val, irq;
    logic [10:0] fetch_addr;
    logic        squash, gie, w_load;
    logic [7:0]  w_lit;

    always #5 clk = ~clk;

    prog_sequencer uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .insn       (insn),
        .cond_zero  (cond_zero),
        .bit_val    (bit_val),
        .irq        (irq),
        .fetch_addr (fetch_addr),
        .squash     (squash),
        .gie        (gie),
        .w_load     (w_load),
        .w_lit      (w_lit)
    );

    int checks = 0;
    int fails  = 0;

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    typedef struct packed {
        logic [3:0]  req;
        logic [13:0] insn;
        logic        cz, bv, irq, wl;
        logic [10:0] fa;
        logic        sq, ge;
    } vec_t;

    localparam int NV = 42;
    localparam vec_t VECS [NV] = '{
        '{4'd2,  14'h0000, 1'b0,1'b0,1'b0,1'b0, 11'h001, 1'b0,1'b0}, // R2 NOP
        '{4'd2,  14'h0700, 1'b0,1'b0,1'b0,1'b0, 11'h002, 1'b0,1'b0}, // R2 arithmetic
        '{4'd3,  14'h2810, 1'b0,1'b0,1'b0,1'b0, 11'h010, 1'b1,1'b0}, // R3 jump 0x010
        '{4'd10, 14'h2055, 1'b1,1'b0,1'b0,1'b0, 11'h011, 1'b0,1'b0}, // R10 dead call
        '{4'd4,  14'h2100, 1'b0,1'b0,1'b0,1'b0, 11'h100, 1'b1,1'b0}, // R4 call, push 0x011
        '{4'd10, 14'h0008, 1'b0,1'b0,1'b0,1'b0, 11'h101, 1'b0,1'b0}, // R10 dead return
        '{4'd8,  14'h0B20, 1'b0,1'b0,1'b0,1'b0, 11'h102, 1'b0,1'b0}, // R8 dec, nonzero
        '{4'd8,  14'h0B20, 1'b1,1'b0,1'b0,1'b0, 11'h103, 1'b1,1'b0}, // R8 dec, zero
        '{4'd10, 14'h0009, 1'b0,1'b0,1'b0,1'b0, 11'h104, 1'b0,1'b0}, // R10 dead retfie
        '{4'd8,  14'h0F21, 1'b1,1'b0,1'b0,1'b0, 11'h105, 1'b1,1'b0}, // R8 inc, zero
        '{4'd10, 14'h3411, 1'b0,1'b0,1'b0,1'b0, 11'h106, 1'b0,1'b0}, // R10 dead retlw
        '{4'd9,  14'h1820, 1'b0,1'b1,1'b0,1'b0, 11'h107, 1'b0,1'b0}, // R9 clear-test, bit 1
        '{4'd9,  14'h1820, 1'b0,1'b0,1'b0,1'b0, 11'h108, 1'b1,1'b0}, // R9 clear-test, bit 0
        '{4'd10, 14'h2800, 1'b0,1'b0,1'b0,1'b0, 11'h109, 1'b0,1'b0}, // R10 dead jump
        '{4'd9,  14'h1C20, 1'b0,1'b0,1'b0,1'b0, 11'h10A, 1'b0,1'b0}, // R9 set-test, bit 0
        '{4'd9,  14'h1C20, 1'b0,1'b1,1'b0,1'b0, 11'h10B, 1'b1,1'b0}, // R9 set-test, bit 1
        '{4'd10, 14'h1C00, 1'b0,1'b1,1'b0,1'b0, 11'h10C, 1'b0,1'b0}, // R10 dead skip
        '{4'd13, 14'h0063, 1'b0,1'b0,1'b0,1'b0, 11'h10D, 1'b0,1'b0}, // R13 sleep
        '{4'd13, 14'h0064, 1'b0,1'b0,1'b0,1'b0, 11'h10E, 1'b0,1'b0}, // R13 watchdog clear
        '{4'd11, 14'h0000, 1'b0,1'b0,1'b1,1'b0, 11'h10F, 1'b0,1'b0}, // R11 masked irq
        '{4'd6,  14'h345A, 1'b0,1'b0,1'b0,1'b1, 11'h011, 1'b1,1'b0}, // R6 retlw 0x5A
        '{4'd10, 14'h0000, 1'b0,1'b0,1'b0,1'b0, 11'h012, 1'b0,1'b0}, // R10
        '{4'd4,  14'h2200, 1'b0,1'b0,1'b0,1'b0, 11'h200, 1'b1,1'b0}, // R4 push 0x012
        '{4'd10, 14'h0000, 1'b0,1'b0,1'b0,1'b0, 11'h201, 1'b0,1'b0}, // R10
        '{4'd7,  14'h0009, 1'b0,1'b0,1'b0,1'b0, 11'h012, 1'b1,1'b1}, // R7 retfie
        '{4'd10, 14'h0000, 1'b0,1'b0,1'b1,1'b0, 11'h013, 1'b0,1'b1}, // R10 irq in dead slot
        '{4'd11, 14'h0000, 1'b0,1'b0,1'b1,1'b0, 11'h004, 1'b1,1'b0}, // R11 entry, push 0x013
        '{4'd10, 14'h0000, 1'b0,1'b0,1'b0,1'b0, 11'h005, 1'b0,1'b0}, // R10
        '{4'd5,  14'h0008, 1'b0,1'b0,1'b0,1'b0, 11'h013, 1'b1,1'b0}, // R5 return
        '{4'd10, 14'h0000, 1'b0,1'b0,1'b0,1'b0, 11'h014, 1'b0,1'b0}, // R10
        '{4'd4,  14'h2300, 1'b0,1'b0,1'b0,1'b0, 11'h300, 1'b1,1'b0}, // R4 push 0x014
        '{4'd10, 14'h0000, 1'b0,1'b0,1'b0,1'b0, 11'h301, 1'b0,1'b0}, // R10
        '{4'd7,  14'h0009, 1'b0,1'b0,1'b0,1'b0, 11'h014, 1'b1,1'b1}, // R7 retfie
        '{4'd10, 14'h0000, 1'b0,1'b0,1'b0,1'b0, 11'h015, 1'b0,1'b1}, // R10
        '{4'd11, 14'h2840, 1'b0,1'b0,1'b1,1'b0, 11'h040, 1'b1,1'b1}, // R11 deferred by jump
        '{4'd11, 14'h0000, 1'b0,1'b0,1'b1,1'b0, 11'h041, 1'b0,1'b1}, // R11 deferred, dead slot
        '{4'd11, 14'h1C20, 1'b0,1'b1,1'b1,1'b0, 11'h042, 1'b1,1'b1}, // R11 deferred by skip
        '{4'd11, 14'h0000, 1'b0,1'b0,1'b1,1'b0, 11'h043, 1'b0,1'b1}, // R11 dead slot
        '{4'd11, 14'h0700, 1'b0,1'b0,1'b1,1'b0, 11'h004, 1'b1,1'b0}, // R11 entry, push 0x043
        '{4'd10, 14'h0000, 1'b0,1'b0,1'b0,1'b0, 11'h005, 1'b0,1'b0}, // R10
        '{4'd5,  14'h0008, 1'b0,1'b0,1'b0,1'b0, 11'h043, 1'b1,1'b0}, // R5 return
        '{4'd10, 14'h0000, 1'b0,1'b0,1'b0,1'b0, 11'h044, 1'b0,1'b0}  // R10
    };

    task automatic step(input logic [13:0] w, input logic cz, input logic bv, input logic rq);
        insn = w; cond_zero = cz; bit_val = bv; irq = rq;
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        insn = '0; cond_zero = 1'b0; bit_val = 1'b0; irq = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1", "fetch in reset", 32'(fetch_addr), 32'h0);
        check("R1", "squash in reset", 32'(squash), 32'h0);
        rst_n = 1'b1;
        #1;
        check("R1", "fetch after reset", 32'(fetch_addr), 32'h0);
        check("R1", "squash after reset", 32'(squash), 32'h0);
        check("R1", "gie after reset", 32'(gie), 32'h0);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        vec_t        v;
        logic [10:0] pushed [9];
        string       rq;

        do_reset();

        for (int i = 0; i < NV; i++) begin
            v = VECS[i];
            rq = $sformatf("R%0d", v.req);
            insn = v.insn; cond_zero = v.cz; bit_val = v.bv; irq = v.irq;
            #1;
            check(rq, "w_load", 32'(w_load), 32'(v.wl));
            if (v.wl) check(rq, "w_lit", 32'(w_lit), 32'(v.insn[7:0]));
            @(posedge clk);
            @(negedge clk);
            check(rq, "fetch_addr", 32'(fetch_addr), 32'(v.fa));
            check(rq, "squash", 32'(squash), 32'(v.sq));
            check(rq, "gie", 32'(gie), 32'(v.ge));
        end

        // reset taken with gie set and a non-empty stack (R1)
        step(14'h2300, 1'b0, 1'b0, 1'b0);
        step(14'h0000, 1'b0, 1'b0, 1'b0);
        step(14'h0009, 1'b0, 1'b0, 1'b0);
        check("R7", "gie before reset", 32'(gie), 32'h1);
        do_reset();

        // R12: nine calls overflow the 8-entry stack, then nine returns
        step(14'h0000, 1'b0, 1'b0, 1'b0);
        for (int i = 0; i < 9; i++) begin
            logic [10:0] tgt;
            tgt = 11'h100 + 11'(i * 16);
            pushed[i] = fetch_addr;
            step({3'b100, tgt}, 1'b0, 1'b0, 1'b0);
            check("R12", "call target", 32'(fetch_addr), 32'(tgt));
            step(14'h0000, 1'b0, 1'b0, 1'b0);
        end
        for (int k = 0; k < 9; k++) begin
            logic [10:0] exp_a;
            exp_a = (k < 8) ? pushed[8 - k] : pushed[8];
            step(14'h0008, 1'b0, 1'b0, 1'b0);
            check("R12", "wrapped return", 32'(fetch_addr), 32'(exp_a));
            check("R12", "return squash", 32'(squash), 32'h1);
            step(14'h0000, 1'b0, 1'b0, 1'b0);
        end

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule